// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block is the command front end of a NOR-style flash device. A host drives a strobe bus made of active-low chip enable, write enable and output enable, and the block samples that bus with a system clock. When a write strobe ends, the block takes the low data byte as a command. It tracks the two-step program and erase sequences, and it handles erase suspend and resume. It also decides what a bus read returns: array contents, one of two identifier words, or the status byte.

An internal program/erase engine is modelled by a busy level and a done pulse that carries a failure flag. The block sends the engine one-cycle start, suspend and resume pulses, along with the address and data captured for the operation. The block holds the error bits of the status byte. These bits stay set until software clears them with a command.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A bus write is taken only while output enable is high and chip enable and write enable are both low. It is committed when that condition ends, which happens as soon as either enable rises. A write strobe applied with output enable low has no effect.
- R2: Only data bits 7:0 form the command code. Bits 15:8 are ignored when a command is decoded.
- R3: After reset the block is in array-read mode, and the status byte reads 80h.
- R4: FFh selects array read, 90h selects identifier read and 70h selects status read. In identifier mode, address bit 0 = 0 returns MFR_ID and address bit 0 = 1 returns DEV_ID.
- R5: 40h or 10h arms a program. The next committed bus write pulses prog_start for one cycle, with op_addr/op_data taken from that write, and selects status read.
- R6: An erase starts, with one erase_start pulse, only when 20h is directly followed by D0h. Any other second code sets the sequence-error bit instead, and status read is selected in both cases.
- R7: 00h, a stray D0h and every code not listed are invalid when the engine is idle. An invalid code sets status bit 3 and selects status read.
- R8: The status layout is: bit 7 = ready (the inverse of eng_busy), bit 6 = erase suspended, bit 5 = erase failed, bit 4 = program failed, bit 3 = sequence error, and bits 15:8 and 2:0 read zero. A done pulse with eng_err set sets bit 5 for an erase and bit 4 for a program.
- R9: 50h clears status bits 5:3. Nothing else clears them.
- R10: While eng_busy is high, reads return the status byte whatever read mode is selected.
- R11: B0h during an erase pulses suspend_req and sets bit 6. While suspended, only 70h, FFh and D0h act. D0h pulses resume_req and clears bit 6, and all other codes change nothing.
- R12: While the engine is busy and not suspended, any code other than FFh, 70h, or B0h during an erase is a sequence error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Bus address |
| dq_in | input | DATA_W | Bus write data |
| array_rdata | input | DATA_W | Array word for the current address |
| eng_busy | input | 1 | Engine operation in progress |
| eng_done | input | 1 | Engine finished (one-cycle pulse) |
| eng_err | input | 1 | Engine failure flag, valid with eng_done |
| rd_data | output | DATA_W | Bus read data |
| prog_start | output | 1 | Program start pulse |
| erase_start | output | 1 | Erase start pulse |
| suspend_req | output | 1 | Erase suspend pulse |
| resume_req | output | 1 | Erase resume pulse |
| op_addr | output | ADDR_W | Address of the started operation |
| op_data | output | DATA_W | Data of the started program |

## Verification
A wrong sequencer state shows up at the ports as a missing or unexpected start, suspend or resume pulse, in the cycle right after the bus write that ends the strobe. A wrong read-mode register appears on the next bus read as array data where status was expected, or as the reverse. A lost or stuck error bit appears on the first status read after the event. Suspend-mode filtering is checked by issuing a disallowed code and then reading both status and array data before the next allowed command.

// File: rtl/flash_cmd_pkg.sv
// Shared command codes, mode and state types, and status bit positions
// for the flash command sequencer. Assumes an 8-bit command on the low byte.
package flash_cmd_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [CMD_W-1:0] CMD_IDENT       = 8'h90;
    localparam logic [CMD_W-1:0] CMD_READ_STAT   = 8'h70;
    localparam logic [CMD_W-1:0] CMD_CLR_STAT    = 8'h50;
    localparam logic [CMD_W-1:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [CMD_W-1:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [CMD_W-1:0] CMD_PROG_SETUP1 = 8'h40;
    localparam logic [CMD_W-1:0] CMD_PROG_SETUP2 = 8'h10;
    localparam logic [CMD_W-1:0] CMD_SUSPEND     = 8'hB0;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2
    } rmode_e;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_PROG_ARMED  = 2'd1,
        ST_ERASE_ARMED = 2'd2,
        ST_SUSPENDED   = 2'd3
    } seq_e;

    localparam int STAT_READY      = 7;
    localparam int STAT_SUSP       = 6;
    localparam int STAT_ERASE_FAIL = 5;
    localparam int STAT_PROG_FAIL  = 4;
    localparam int STAT_SEQ_ERR    = 3;
    localparam int ERR_BITS        = 3;

endpackage

// File: rtl/flash_bus_capture.sv
// Bus write capture: registers address and data on every clock while a
// write strobe is active. It raises commit for one cycle when the strobe
// ends, that is when either chip enable or write enable rises first.
// Assumes the strobes are already synchronous to clk.
module flash_bus_capture #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic              commit,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);

    logic wr_act;
    logic wr_act_q;

    // Write strobe is valid only with output enable high.
    always_comb wr_act = !ce_n && !we_n && oe_n;

    // Track the strobe and hold the last address/data seen during it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            wr_act_q <= wr_act;
            if (wr_act) begin
                cap_addr <= addr;
                cap_data <= dq_in;
            end
        end
    end

    // Falling edge of the active condition ends the bus write.
    always_comb commit = wr_act_q && !wr_act;

endmodule

// File: rtl/flash_seq_fsm.sv
// Command sequencer: decodes committed codes and tracks the two-step
// program and erase sequences and erase suspend. It selects the read mode
// and issues one-cycle engine pulses. Assumes the engine raises busy the
// cycle after a start pulse and drops it while suspended.
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              eng_busy,
    input  logic              eng_done,
    output rmode_e            rmode,
    output logic              suspended,
    output logic              erasing,
    output logic              prog_start,
    output logic              erase_start,
    output logic              suspend_req,
    output logic              resume_req,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              set_seq_err,
    output logic              clr_err
);

    seq_e             state, state_n;
    rmode_e           rmode_n;
    logic             prog_go, erase_go, susp_go, res_go;
    logic [CMD_W-1:0] cmd;

    // Command code is the low byte only.
    always_comb cmd = cap_data[CMD_W-1:0];

    // Next-state and action decode for one committed bus write.
    always_comb begin
        state_n     = state;
        rmode_n     = rmode;
        prog_go     = 1'b0;
        erase_go    = 1'b0;
        susp_go     = 1'b0;
        res_go      = 1'b0;
        set_seq_err = 1'b0;
        clr_err     = 1'b0;
        if (commit) begin
            case (state)
                ST_PROG_ARMED: begin
                    prog_go = 1'b1;
                    state_n = ST_IDLE;
                    rmode_n = RM_STATUS;
                end
                ST_ERASE_ARMED: begin
                    state_n = ST_IDLE;
                    rmode_n = RM_STATUS;
                    if (cmd == CMD_CONFIRM) erase_go = 1'b1;
                    else                    set_seq_err = 1'b1;
                end
                ST_SUSPENDED: begin
                    case (cmd)
                        CMD_READ_STAT:  rmode_n = RM_STATUS;
                        CMD_READ_ARRAY: rmode_n = RM_ARRAY;
                        CMD_CONFIRM: begin
                            res_go  = 1'b1;
                            state_n = ST_IDLE;
                            rmode_n = RM_STATUS;
                        end
                        default: ;
                    endcase
                end
                default: begin
                    if (eng_busy) begin
                        case (cmd)
                            CMD_READ_ARRAY: rmode_n = RM_ARRAY;
                            CMD_READ_STAT:  rmode_n = RM_STATUS;
                            CMD_SUSPEND: begin
                                if (erasing) begin
                                    susp_go = 1'b1;
                                    state_n = ST_SUSPENDED;
                                end else begin
                                    set_seq_err = 1'b1;
                                    rmode_n     = RM_STATUS;
                                end
                            end
                            default: begin
                                set_seq_err = 1'b1;
                                rmode_n     = RM_STATUS;
                            end
                        endcase
                    end else begin
                        case (cmd)
                            CMD_READ_ARRAY: rmode_n = RM_ARRAY;
                            CMD_IDENT:      rmode_n = RM_IDENT;
                            CMD_READ_STAT:  rmode_n = RM_STATUS;
                            CMD_CLR_STAT:   clr_err = 1'b1;
                            CMD_SUSPEND:    ;
                            CMD_ERASE_SETUP: begin
                                state_n = ST_ERASE_ARMED;
                                rmode_n = RM_STATUS;
                            end
                            CMD_PROG_SETUP1, CMD_PROG_SETUP2: begin
                                state_n = ST_PROG_ARMED;
                                rmode_n = RM_STATUS;
                            end
                            default: begin
                                set_seq_err = 1'b1;
                                rmode_n     = RM_STATUS;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // State, read mode and registered engine pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            rmode       <= RM_ARRAY;
            prog_start  <= 1'b0;
            erase_start <= 1'b0;
            suspend_req <= 1'b0;
            resume_req  <= 1'b0;
            op_addr     <= '0;
            op_data     <= '0;
        end else begin
            state       <= state_n;
            rmode       <= rmode_n;
            prog_start  <= prog_go;
            erase_start <= erase_go;
            suspend_req <= susp_go;
            resume_req  <= res_go;
            if (prog_go || erase_go) begin
                op_addr <= cap_addr;
                op_data <= cap_data;
            end
        end
    end

    // Remembers that the running operation is an erase.
    always_ff @(posedge clk) begin
        if (!rst_n)        erasing <= 1'b0;
        else if (erase_go) erasing <= 1'b1;
        else if (eng_done) erasing <= 1'b0;
    end

    always_comb suspended = (state == ST_SUSPENDED);

endmodule

// File: rtl/flash_status_bits.sv
// Status byte: holds the sticky error bits, which only a clear command
// resets, and combines them with ready and suspend. Assumes eng_err is
// meaningful only while eng_done is high.
module flash_status_bits
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eng_busy,
    input  logic       eng_done,
    input  logic       eng_err,
    input  logic       erasing,
    input  logic       suspended,
    input  logic       set_seq_err,
    input  logic       clr_err,
    output logic [7:0] status
);

    // err_q[0] sequence, err_q[1] program failure, err_q[2] erase failure
    logic [ERR_BITS-1:0] err_q, err_n;

    // Apply clear first, then any new error event.
    always_comb begin
        err_n = clr_err ? '0 : err_q;
        if (set_seq_err) err_n[0] = 1'b1;
        if (eng_done && eng_err) begin
            if (erasing) err_n[2] = 1'b1;
            else         err_n[1] = 1'b1;
        end
    end

    // Sticky error register.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_n;
    end

    // Assemble the byte seen by a status read.
    always_comb begin
        status                  = '0;
        status[STAT_READY]      = !eng_busy;
        status[STAT_SUSP]       = suspended;
        status[STAT_ERASE_FAIL] = err_q[2];
        status[STAT_PROG_FAIL]  = err_q[1];
        status[STAT_SEQ_ERR]    = err_q[0];
    end

endmodule

// File: rtl/flash_read_mux.sv
// Read path: picks array data, an identifier word or the status byte.
// A busy engine forces status. Assumes identifier selection uses address bit 0.
module flash_read_mux
    import flash_cmd_pkg::*;
#(
    parameter int              DATA_W = 16,
    parameter logic [DATA_W-1:0] MFR_ID = 16'h00A7,
    parameter logic [DATA_W-1:0] DEV_ID = 16'h3C5B
) (
    input  rmode_e            rmode,
    input  logic              eng_busy,
    input  logic [7:0]        status,
    input  logic              addr_lsb,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] rd_data
);

    // Select the read source.
    always_comb begin
        if (eng_busy || rmode == RM_STATUS) begin
            rd_data      = '0;
            rd_data[7:0] = status;
        end else if (rmode == RM_IDENT) begin
            rd_data = addr_lsb ? DEV_ID : MFR_ID;
        end else begin
            rd_data = array_rdata;
        end
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top of the flash command interface: bus capture, sequencer, status
// byte and read mux. Assumes a strobe bus synchronous to clk and an
// engine that answers start pulses with a busy/done handshake.
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W = 20,
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] MFR_ID = 16'h00A7,
    parameter logic [DATA_W-1:0] DEV_ID = 16'h3C5B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    input  logic [DATA_W-1:0] array_rdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              eng_err,
    output logic [DATA_W-1:0] rd_data,
    output logic              prog_start,
    output logic              erase_start,
    output logic              suspend_req,
    output logic              resume_req,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);

    logic              commit;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    rmode_e            rmode;
    logic              suspended;
    logic              erasing;
    logic              set_seq_err;
    logic              clr_err;
    logic [7:0]        status_byte;

    flash_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .dq_in    (dq_in),
        .commit   (commit),
        .cap_addr (cap_addr),
        .cap_data (cap_data)
    );

    flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .cap_addr    (cap_addr),
        .cap_data    (cap_data),
        .eng_busy    (eng_busy),
        .eng_done    (eng_done),
        .rmode       (rmode),
        .suspended   (suspended),
        .erasing     (erasing),
        .prog_start  (prog_start),
        .erase_start (erase_start),
        .suspend_req (suspend_req),
        .resume_req  (resume_req),
        .op_addr     (op_addr),
        .op_data     (op_data),
        .set_seq_err (set_seq_err),
        .clr_err     (clr_err)
    );

    flash_status_bits stat_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .eng_busy    (eng_busy),
        .eng_done    (eng_done),
        .eng_err     (eng_err),
        .erasing     (erasing),
        .suspended   (suspended),
        .set_seq_err (set_seq_err),
        .clr_err     (clr_err),
        .status      (status_byte)
    );

    flash_read_mux #(.DATA_W(DATA_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) mux_i (
        .rmode       (rmode),
        .eng_busy    (eng_busy),
        .status      (status_byte),
        .addr_lsb    (addr[0]),
        .array_rdata (array_rdata),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
// Property checker bound to flash_cmd_ctrl. It observes ports and the
// signals passed between the capture, sequencer and status blocks.
module flash_cmd_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic [7:0]        cmd,
    input logic              prog_start,
    input logic              erase_start,
    input logic              eng_busy,
    input logic              eng_done,
    input logic [DATA_W-1:0] rd_data,
    input logic [7:0]        status,
    input logic              suspended,
    input logic              clr_err
);

    // R5 / R6: an operation never starts as both program and erase
    assert_single_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_start && erase_start));

    // R6: an erase pulse always follows a committed confirm code
    assert_erase_confirmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> $past(commit && cmd == 8'hD0));

    // R10: a busy engine forces a status read showing not ready
    assert_busy_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> (rd_data[DATA_W-1:7] == '0));

    // R9: clear leaves error bits zero when no engine result lands
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !eng_done) |=> (status[5:3] == 3'b000));

    // R9: an error bit falls only after a clear
    assert_errors_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status[5:3]) & ~status[5:3])) |-> $past(clr_err));

    // R11: suspend is entered only through a suspend code
    assert_suspend_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> $past(commit && cmd == 8'hB0));

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .cmd         (cap_data[7:0]),
    .prog_start  (prog_start),
    .erase_start (erase_start),
    .eng_busy    (eng_busy),
    .eng_done    (eng_done),
    .rd_data     (rd_data),
    .status      (status_byte),
    .suspended   (suspended),
    .clr_err     (clr_err)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected words, a monitor compares them.
module flash_cmd_ctrl_tb_top;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam logic [DATA_W-1:0] MFR = 16'h00A7;
    localparam logic [DATA_W-1:0] DEV = 16'h3C5B;
    localparam int ENG_CYCLES = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] dq_in = '0;
    logic [DATA_W-1:0] array_rdata;
    logic              eng_busy = 1'b0, eng_done = 1'b0, eng_err;
    logic              err_cfg = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              prog_start, erase_start, suspend_req, resume_req;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_data;

    int vectors = 0;
    int errors  = 0;
    int n_prog = 0, n_erase = 0, n_susp = 0, n_res = 0;
    int eng_cnt = 0;
    logic [ADDR_W-1:0] seen_addr = '0;
    logic [DATA_W-1:0] seen_data = '0;

    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];
    event              sample_ev;

    always #4 clk = ~clk;

    assign array_rdata = 16'hA500 ^ addr[15:0];
    assign eng_err     = err_cfg;

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_ID(MFR), .DEV_ID(DEV)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .array_rdata(array_rdata),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_err(eng_err),
        .rd_data(rd_data), .prog_start(prog_start), .erase_start(erase_start),
        .suspend_req(suspend_req), .resume_req(resume_req),
        .op_addr(op_addr), .op_data(op_data)
    );

    // Behavioural engine: busy for ENG_CYCLES, halts on suspend.
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (prog_start || erase_start) begin
            eng_busy <= 1'b1;
            eng_cnt  <= ENG_CYCLES;
        end else if (suspend_req) begin
            eng_busy <= 1'b0;
        end else if (resume_req) begin
            eng_busy <= 1'b1;
        end else if (eng_busy) begin
            eng_cnt <= eng_cnt - 1;
            if (eng_cnt == 1) begin
                eng_busy <= 1'b0;
                eng_done <= 1'b1;
            end
        end
    end

    // Pulse monitor.
    always @(posedge clk) begin
        if (prog_start)  begin n_prog  <= n_prog + 1;  seen_addr <= op_addr; seen_data <= op_data; end
        if (erase_start) begin n_erase <= n_erase + 1; seen_addr <= op_addr; end
        if (suspend_req) n_susp <= n_susp + 1;
        if (resume_req)  n_res  <= n_res + 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares read data with the queued expectation.
    always @(sample_ev) begin
        while (exp_q.size() > 0) begin
            check(tag_q.pop_front(), {16'h0, rd_data}, {16'h0, exp_q.pop_front()});
        end
    end

    task automatic bus_write(input logic [DATA_W-1:0] d, input logic [ADDR_W-1:0] a,
                             input bit oe_low = 1'b0);
        @(negedge clk);
        addr = a; dq_in = d; oe_n = oe_low ? 1'b0 : 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                            input string tag);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(posedge clk);
        #2;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        ->sample_ev;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R3: array mode and idle status after reset
        bus_read(20'h9, 16'hA509, "R3 array after reset");
        bus_write(16'h0070, '0);
        bus_read(20'h0, 16'h0080, "R3 reset status");
        // R2: junk upper byte on FFh
        bus_write(16'h5AFF, '0);
        bus_read(20'h5, 16'hA505, "R2 upper byte ignored");
        // R1: write with output enable low has no effect
        bus_write(16'h0090, '0, 1'b1);
        bus_read(20'h5, 16'hA505, "R1 oe-low write ignored");
        // R4: identifier words
        bus_write(16'h7790, '0);
        bus_read(20'h0, MFR, "R4 manufacturer id");
        bus_read(20'h1, DEV, "R4 device id");
        // R7: invalid code and stray confirm
        bus_write(16'h0000, '0);
        bus_read(20'h0, 16'h0088, "R7 code 00h error");
        bus_write(16'h0050, '0);
        bus_read(20'h0, 16'h0080, "R9 clear status");
        bus_write(16'h00D0, '0);
        bus_read(20'h0, 16'h0088, "R7 stray D0h error");
        bus_write(16'h0050, '0);
        // R5: program sequence
        bus_write(16'h0040, '0);
        bus_write(16'hBEEF, 20'h00123);
        check("R5 prog pulses", n_prog, 1);
        check("R5 prog addr", {12'h0, seen_addr}, 32'h00123);
        check("R5 prog data", {16'h0, seen_data}, 32'hBEEF);
        bus_read(20'h0, 16'h0000, "R5 busy status");
        // R10: array mode while busy still reads status
        bus_write(16'h00FF, '0);
        bus_read(20'h4, 16'h0000, "R10 busy forces status");
        // R12: identify while busy is an error
        bus_write(16'h0090, '0);
        bus_read(20'h0, 16'h0008, "R12 busy command error");
        repeat (40) @(negedge clk);
        bus_read(20'h0, 16'h0088, "R8 ready with seq error");
        bus_write(16'h0050, '0);
        // R8: program failure with alternate setup code
        err_cfg = 1'b1;
        bus_write(16'h0010, '0);
        bus_write(16'h1234, 20'h7);
        repeat (40) @(negedge clk);
        bus_read(20'h0, 16'h0090, "R8 program fail bit");
        check("R5 second prog pulse", n_prog, 2);
        err_cfg = 1'b0;
        bus_write(16'h0050, '0);
        // R6: mismatched second cycle
        bus_write(16'h0020, '0);
        bus_write(16'h00FF, '0);
        bus_read(20'h0, 16'h0088, "R6 mismatch error");
        check("R6 no erase on mismatch", n_erase, 0);
        bus_write(16'h0050, '0);
        // R6 / R11: erase, suspend, filter, resume
        bus_write(16'h0020, '0);
        bus_write(16'h00D0, 20'h00040);
        check("R6 erase pulse", n_erase, 1);
        check("R6 erase addr", {12'h0, seen_addr}, 32'h40);
        bus_write(16'h00B0, '0);
        check("R11 suspend pulse", n_susp, 1);
        bus_read(20'h0, 16'h00C0, "R11 suspended status");
        bus_write(16'h0090, '0);
        bus_read(20'h0, 16'h00C0, "R11 identify ignored");
        bus_write(16'h00FF, '0);
        bus_read(20'h3, 16'hA503, "R11 array in suspend");
        err_cfg = 1'b1;
        bus_write(16'h00D0, '0);
        check("R11 resume pulse", n_res, 1);
        bus_read(20'h0, 16'h0000, "R11 resumed busy");
        repeat (40) @(negedge clk);
        bus_read(20'h0, 16'h00A0, "R8 erase fail bit");
        err_cfg = 1'b0;
        bus_write(16'h0050, '0);
        // R9: error bit survives other commands
        bus_write(16'h0033, '0);
        bus_write(16'h00FF, '0);
        bus_read(20'h2, 16'hA502, "R4 array reselected");
        bus_write(16'h0070, '0);
        bus_read(20'h0, 16'h0088, "R9 error sticky");
        bus_write(16'h0050, '0);
        bus_read(20'h0, 16'h0080, "R9 final clear");
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule